// File: doc/BRIEF.md
# One-Shot CPU Cycle Timer Interrupt

This block is a single-shot down counter that measures a programmed number of CPU bus cycles and then raises an interrupt. Software loads the 16-bit count as two bytes. A write to the upper-byte register only stores those bits. A write to the lower-byte register stores the low bits and starts the countdown if the full value is not zero. Each CPU-cycle strobe then takes one off the live count. When the count steps from one to zero, the block sets a status flag, drives the interrupt and stops. It does not reload.

The lower-byte address also acts as the status register. A read returns the flag in the top bit, and the read acknowledges the interrupt. A watcher on the CPU-cycle strobe treats a long gap in the strobes as a system reset and aborts any countdown in progress. The block runs on a free-running system clock. The CPU-cycle strobe and the register strobes are single-clock pulses in that domain. The block works on its own, apart from any other interrupt source.

Top module: `cyc_timer_irq`

## Requirements
- R1: A write to the upper-byte register (`wr_hi`) loads count bits 15..8 from `wr_data` and never starts a stopped timer.
- R2: A write to the lower-byte register (`wr_lo`) loads count bits 7..0. It leaves the timer running if and only if the resulting 16-bit count is nonzero, so a lower-byte write with a zero result does not start it.
- R3: While running, the count drops by one on each clock in which `cpu_tick` is high. Without a strobe, a write or a gap, the count holds.
- R4: The step from count 1 to count 0 sets the flag, raises `irq` on the same clock edge and stops the timer. The count then stays at zero, so further strobes raise no new interrupt.
- R5: `stat_data` carries the flag in bit 7 and zeros in bits 6..0. A `rd_stat` strobe clears both the flag and `irq`. An expiry in the same clock as the read wins, and the flag stays set.
- R6: When `GAP_CYC` system clocks pass with no `cpu_tick`, the timer stops, the count clears to zero, and the flag and `irq` clear. A gap shorter than `GAP_CYC` has no effect.
- R7: After reset the count is zero, the timer is stopped, and the flag and `irq` are low.
- R8: A write in the same clock as a decrement takes priority for the written byte. The other byte takes its decremented value, and that clock cannot produce an expiry.
- R9: A write to either byte while the timer is running replaces only that byte of the live count and leaves the other byte alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_tick | input | 1 | One-clock strobe per CPU bus cycle |
| wr_lo | input | 1 | Write strobe for the lower count byte |
| wr_hi | input | 1 | Write strobe for the upper count byte |
| wr_data | input | 8 | Write data |
| rd_stat | input | 1 | Read strobe for the status (lower-byte) address |
| stat_data | output | 8 | Status read data, flag in bit 7 |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong count shows up only as an interrupt on the wrong strobe. So each count is checked by sampling `irq` one strobe before the expected expiry and again on the expected strobe. Counts above 255 make sure that a wrong borrow into the upper byte, or an overwrite of the wrong byte, moves the expiry by at least 256 strobes. A wrongly running or stopped state shows one strobe later as a missing or extra interrupt. A flag that fails to clear shows at once in `stat_data` after the read or the gap.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned STAT_FLAG_BIT = BYTE_W - 1;

  typedef logic [CNT_W-1:0]  tmr_cnt_t;
  typedef logic [BYTE_W-1:0] tmr_byte_t;

  function automatic int unsigned idle_width(input int unsigned gap);
    return (gap < 2) ? 1 : $clog2(gap + 1);
  endfunction
endpackage

// File: rtl/cyc_idle_watch.sv
module cyc_idle_watch #(
  parameter int unsigned GAP_CYC = 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic gap_o
);
  localparam int unsigned IW = cyc_timer_pkg::idle_width(GAP_CYC);
  localparam logic [IW-1:0] GAP_LIM = IW'(GAP_CYC);

  logic [IW-1:0] idle_q, idle_n;

  assign gap_o = (idle_q == GAP_LIM);

  always_comb begin
    if (tick)       idle_n = '0;
    else if (gap_o) idle_n = idle_q;
    else            idle_n = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_n;
  end
endmodule

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
  import cyc_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      gap,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  tmr_byte_t wr_data,
  output tmr_cnt_t  cnt_o,
  output logic      run_o,
  output logic      expire_o
);
  tmr_cnt_t cnt_q, cnt_n;
  logic     run_q, run_n;
  logic     dec;

  always_comb begin
    dec      = run_q & tick;
    cnt_n    = dec ? (cnt_q - 1'b1) : cnt_q;
    if (wr_hi) cnt_n[CNT_W-1:BYTE_W] = wr_data;
    if (wr_lo) cnt_n[BYTE_W-1:0]     = wr_data;
    run_n    = run_q;
    expire_o = 1'b0;
    if (wr_lo)
      run_n = (cnt_n != '0);
    else if (wr_hi)
      run_n = run_q && (cnt_n != '0);
    else if (dec && (cnt_q == tmr_cnt_t'(1))) begin
      run_n    = 1'b0;
      expire_o = 1'b1;
    end
    if (gap) begin
      cnt_n    = '0;
      run_n    = 1'b0;
      expire_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/cyc_timer_flag.sv
module cyc_timer_flag
  import cyc_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set,
  input  logic      rd,
  input  logic      gap,
  output logic      flag_o,
  output tmr_byte_t stat_o
);
  logic flag_q, flag_n;

  always_comb begin
    flag_n = flag_q;
    if (rd)  flag_n = 1'b0;
    if (set) flag_n = 1'b1;
    if (gap) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_n;
  end

  assign flag_o = flag_q;

  always_comb begin
    stat_o = '0;
    stat_o[STAT_FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/cyc_timer_irq.sv
module cyc_timer_irq
  import cyc_timer_pkg::*;
#(
  parameter int unsigned GAP_CYC = 550
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_tick,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wr_data,
  input  logic        rd_stat,
  output logic [7:0]  stat_data,
  output logic        irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       gap_hit;
  logic       expire;
  logic       tmr_run;
  tmr_cnt_t   tmr_cnt;
  logic       flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cyc_idle_watch #(.GAP_CYC(GAP_CYC)) u_idle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (cpu_tick),
    .gap_o (gap_hit)
  );

  cyc_timer_core u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (cpu_tick),
    .gap      (gap_hit),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .cnt_o    (tmr_cnt),
    .run_o    (tmr_run),
    .expire_o (expire)
  );

  cyc_timer_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (expire),
    .rd     (rd_stat),
    .gap    (gap_hit),
    .flag_o (flag),
    .stat_o (stat_data)
  );

  assign irq = flag;
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_tick,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic        rd_stat,
  input logic        irq,
  input logic        gap_hit,
  input logic        expire,
  input logic        tmr_run,
  input logic [15:0] tmr_cnt
);
  AST_HI_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_run && wr_hi && !wr_lo) |=> !tmr_run); // R1

  AST_LO_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !gap_hit) |=> (tmr_run == (tmr_cnt != 16'd0))); // R2

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && cpu_tick && !wr_lo && !wr_hi && !gap_hit)
      |=> (tmr_cnt == $past(tmr_cnt) - 16'd1)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_tick && !wr_lo && !wr_hi && !gap_hit) |=> $stable(tmr_cnt)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tmr_run && cpu_tick && tmr_cnt == 16'd1)); // R4

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_run |-> (tmr_cnt != 16'd0)); // R4

  AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !expire) |=> !irq); // R5

  AST_GAP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |=> (!irq && !tmr_run && tmr_cnt == 16'd0)); // R6
endmodule

bind cyc_timer_irq cyc_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cpu_tick (cpu_tick),
  .wr_lo    (wr_lo),
  .wr_hi    (wr_hi),
  .rd_stat  (rd_stat),
  .irq      (irq),
  .gap_hit  (gap_hit),
  .expire   (expire),
  .tmr_run  (tmr_run),
  .tmr_cnt  (tmr_cnt)
);

// File: tb/cyc_timer_irq_bench.sv
module cyc_timer_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 40;
  localparam int NVEC = 7;
  // {count[15:0], strobes[15:0], expected irq}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h0003, 16'd2,   1'b0},
    {16'h0003, 16'd3,   1'b1},
    {16'h0001, 16'd1,   1'b1},
    {16'h0100, 16'd255, 1'b0},
    {16'h0100, 16'd256, 1'b1},
    {16'h0200, 16'd512, 1'b1},
    {16'h0000, 16'd5,   1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_tick = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, rd_stat = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] stat_data;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_timer_irq #(.GAP_CYC(GAP)) u_cyc_timer_irq (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .rd_stat(rd_stat),
    .stat_data(stat_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic lo, input logic hi,
                     input logic rd, input logic [7:0] d);
    cpu_tick = t; wr_lo = lo; wr_hi = hi; rd_stat = rd; wr_data = d;
    @(posedge clk); #1;
    cpu_tick = 0; wr_lo = 0; wr_hi = 0; rd_stat = 0; wr_data = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic load(input logic [15:0] v);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, v[15:8]);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, v[7:0]);
  endtask

  // strobe plus acknowledge: keeps the gap watcher quiet and clears the flag
  task automatic ack();
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R7 irq after reset", {7'd0, irq}, 8'h00);
    check("R7 status after reset", stat_data, 8'h00);
    ticks(3);
    check("R7 no count after reset", {7'd0, irq}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      ack();
      load(VEC[v][32:17]);
      ticks(int'(VEC[v][16:1]));
      check("R2/R3/R4 vector irq", {7'd0, irq}, {7'd0, VEC[v][0]});
      check("R5 vector status", stat_data, {VEC[v][0], 7'd0});
    end

    // R5 read clears the flag and irq
    ack();
    check("R5 read clears", {stat_data[7:1], irq}, 8'h00);
    check("R5 status zero after read", stat_data, 8'h00);

    // R4 no reload: further strobes after expiry stay quiet
    load(16'h0002); ticks(2); ack();
    ticks(20);
    check("R4 stays stopped", {7'd0, irq}, 8'h00);

    // R1 upper byte only: no start
    ack();
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h01);
    ticks(300);
    check("R1 hi write does not start", {7'd0, irq}, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    ticks(255);
    check("R1 hi byte held, lo starts (255)", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R1 hi byte held, lo starts (256)", {7'd0, irq}, 8'h01);

    // R9 live overwrite of low byte
    ack(); load(16'h000A); ticks(4);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h02);
    ticks(1);
    check("R9 lo overwrite pre", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R9 lo overwrite expiry", {7'd0, irq}, 8'h01);

    // R9 live overwrite of high byte keeps low byte
    ack(); load(16'h0005); ticks(1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h01);
    ticks(259);
    check("R9 hi overwrite pre", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R9 hi overwrite expiry", {7'd0, irq}, 8'h01);

    // R8 write together with decrement: other byte decremented
    ack(); load(16'h0100);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h03);
    ticks(2);
    check("R8 same-cycle write pre", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R8 same-cycle write expiry", {7'd0, irq}, 8'h01);

    // R8 write on the expiring strobe suppresses the expiry
    ack(); load(16'h0002); ticks(1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h02);
    check("R8 write beats expiry", {7'd0, irq}, 8'h00);
    ticks(2);
    check("R8 rewritten count expires", {7'd0, irq}, 8'h01);

    // R5 expiry in the same clock as a read wins
    ack(); load(16'h0002); ticks(1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R5 set beats read", stat_data, 8'h80);

    // R6 gap aborts a running timer
    ack(); load(16'h0005); ticks(2);
    idle(GAP + 5);
    ticks(10);
    check("R6 gap aborts count", {7'd0, irq}, 8'h00);

    // R6 gap clears a pending flag
    ack(); load(16'h0001); ticks(1);
    check("R6 flag set before gap", stat_data, 8'h80);
    idle(GAP + 5);
    check("R6 gap clears flag", stat_data, 8'h00);
    check("R6 gap clears irq", {7'd0, irq}, 8'h00);

    // R6 shorter gap has no effect
    ticks(1); ack(); load(16'h0003); ticks(1);
    idle(GAP - 10);
    ticks(1);
    check("R6 short gap pre", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R6 short gap keeps count", {7'd0, irq}, 8'h01);

    // R2 zero low write with zero high byte does not start
    ack(); load(16'h0000); ticks(70);
    check("R2 zero load stays idle", stat_data, 8'h00);

    finish_run();
  end
endmodule